// File: doc/BRIEF.md
# Radio Mode and Channel Sequencer

This controller sits between a host and a half-duplex narrow-band radio module. It owns the module's supply enable and its two active-low select lines, one for transmit and one for receive. It starts an external synthesizer loader whenever a new channel is requested. It times each settle window with a millisecond timebase, so the `ready` output goes high only once the module can really pass data. When the host asks to transmit, the sequencer selects the transmitter and waits for it to settle. It then drives an alternating 1/0 preamble on the serial data path before it hands that path to the host's own data.

The settle windows depend on history. The first synthesizer load after power-up gets a long window and later loads get a shorter one. A plain mode switch on a channel that is already set gets the shortest window. Lock detect is examined only in a short run of consecutive cycles at the close of a channel window, so any glitching on it during the window is ignored. Channel loads are only ever issued with the receiver selected. A channel request that arrives during transmit drops the module back to receive before the load starts.

The state machine has these states:
- `ST_PWR_OFF` (supply off, both selects high)
- `ST_PWR_ON` (supply on, both selects high)
- `ST_IDLE_RX` (receive selected, no valid channel)
- `ST_LOAD_GO` (one-cycle loader start)
- `ST_LOAD_WAIT` (waiting for the loader to finish)
- `ST_CH_SETTLE` (channel settle window)
- `ST_LOCK_CHK` (lock qualification)
- `ST_RX_SETTLE` (switch to receive on the same channel)
- `ST_RX_READY`
- `ST_TX_SETTLE` (switch to transmit)
- `ST_TX_PRE` (preamble)
- `ST_TX_READY`

Its transitions are:
- power-off window expiry → `ST_PWR_ON`
- power-on window expiry → `ST_IDLE_RX`
- pending channel request from `ST_IDLE_RX`, either settle state or either ready state → `ST_LOAD_GO` → `ST_LOAD_WAIT`
- loader done → `ST_CH_SETTLE`
- window expiry → `ST_LOCK_CHK`
- lock low during the check → `ST_IDLE_RX` with the error flag set
- lock high for the whole check → `ST_RX_READY`
- transmit request from `ST_RX_READY` → `ST_TX_SETTLE`
- window expiry → `ST_TX_PRE`
- window expiry → `ST_TX_READY`
- transmit request dropped in any transmit state → `ST_RX_SETTLE`
- window expiry → `ST_RX_READY`

Top module: `rf_mode_seq`

## Requirements
- R1: While reset is held, `pwr_en` is 0 and both selects are 1. `pwr_en` rises CYC_PER_MS*PWR_MS+1 cycles after reset release with both selects still 1. `rxsel_n` falls a further CYC_PER_MS*PWR_MS+1 cycles later.
- R2: `txsel_n` and `rxsel_n` are never both 0, and neither is 0 while `pwr_en` is 0.
- R3: `ld_start` is only ever 1 while `rxsel_n`=0 and `txsel_n`=1. A channel request taken while transmitting deselects the transmitter and selects the receiver on the second clock edge after the request, in the same cycle as `ld_start`.
- R4: For the first load after power-up, `ready` rises CYC_PER_MS*FIRST_MS+LOCK_N+2 cycles after the edge that samples `ld_done` high, provided lock detect stays high.
- R5: For every later load, `ready` rises CYC_PER_MS*NEXT_MS+LOCK_N+2 cycles after the edge that samples `ld_done`.
- R6: Lock detect is sampled only during the LOCK_N cycles after the channel window closes, so a low pulse earlier in the window changes nothing. A low sample during the check sets `unlock_err` on the next edge, keeps `ready` at 0 and leaves the receiver selected. The next channel request clears `unlock_err` when its load starts.
- R7: Dropping `tx_req` while transmit-ready selects the receiver on the next edge and raises `ready` CYC_PER_MS*SWITCH_MS+1 cycles after that edge.
- R8: Raising `tx_req` while receive-ready selects the transmitter on the next edge. `ready` rises CYC_PER_MS*(SWITCH_MS+PRE_MS)+3 cycles after the request is sampled.
- R9: `tx_dout` is 0 during the transmit settle window. During the preamble window it starts at 1 and inverts every BIT_CYC cycles. In transmit-ready it follows `tx_din`.
- R10: `ready` is 1 only in a ready state, and then exactly one select is 0.
- R11: `tx_req` has no effect while no channel is valid, including after a lock failure: `txsel_n` stays 1 and `ready` stays 0.
- R12: `ld_chan` carries the most recently requested channel number in the cycle `ld_start` is 1, and changes only in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | 1 | One-cycle request to move to channel `ch_num` |
| ch_num | input | CH_W | Requested channel number |
| tx_req | input | 1 | Level: host wants the transmitter |
| lock_det | input | 1 | Synthesizer lock indicator, high when locked |
| ld_done | input | 1 | Loader finished pulse |
| tx_din | input | 1 | Host serial transmit data |
| ld_start | output | 1 | One-cycle start pulse to the synthesizer loader |
| ld_chan | output | CH_W | Channel number for the loader |
| pwr_en | output | 1 | Module supply enable |
| txsel_n | output | 1 | Transmitter select, active low |
| rxsel_n | output | 1 | Receiver select, active low |
| ready | output | 1 | Settled; data may pass in the current mode |
| unlock_err | output | 1 | Lock check failed on the last load |
| tx_dout | output | 1 | Serial data to the modem (preamble or host data) |

## Verification
Every timed result is due a fixed number of rising edges after its stimulus, and that number is built from the window length in ticks plus one edge per state change and LOCK_N edges of lock checking. Two examples: R4 is due 165 edges after `ld_done` is sampled, and R8 is due 103 edges after `tx_req` is sampled. The bench drives each stimulus on a falling edge and counts rising edges from there, sampling on the following falling edge. It checks the output one edge before the due count and again on the due count. Select changes are checked one and two edges after a request. Preamble bits are compared at every falling edge of the window against a pattern derived from BIT_CYC.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;

    typedef enum logic [3:0] {
        ST_PWR_OFF,
        ST_PWR_ON,
        ST_IDLE_RX,
        ST_LOAD_GO,
        ST_LOAD_WAIT,
        ST_CH_SETTLE,
        ST_LOCK_CHK,
        ST_RX_SETTLE,
        ST_RX_READY,
        ST_TX_SETTLE,
        ST_TX_PRE,
        ST_TX_READY
    } seq_state_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfseq_ms_window.sv
module rfseq_ms_window #(
    parameter int CYC_PER_MS = 125000,
    parameter int MS_W       = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [MS_W-1:0] target_ms,
    output logic            expired
);
    localparam int CW = $clog2(CYC_PER_MS + 1);

    logic [CW-1:0]   cyc_q;
    logic [MS_W-1:0] ms_q;

    assign expired = (ms_q >= target_ms);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (restart) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (!expired) begin
            if (cyc_q == CW'(CYC_PER_MS - 1)) begin
                cyc_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // R7: once a window has run out it stays run out until restarted
    p_win_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart) |=> expired);

    // R7: the millisecond count never runs past the target
    p_win_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && ms_q == target_ms) |=> (ms_q == $past(ms_q) || $past(restart)));

endmodule

// File: rtl/rfseq_preamble.sv
module rfseq_preamble #(
    parameter int BIT_CYC = 26042
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bit_o
);
    localparam int BW = $clog2(BIT_CYC + 1);

    logic [BW-1:0] cnt_q;
    logic          bit_q;

    assign bit_o = bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= 1'b1;
        end else if (!en) begin
            cnt_q <= '0;
            bit_q <= 1'b1;
        end else if (cnt_q == BW'(BIT_CYC - 1)) begin
            cnt_q <= '0;
            bit_q <= ~bit_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: every preamble opens with a one
    p_pre_first_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> bit_o);

    // R9: the pattern only moves while enabled
    p_pre_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> bit_o);

endmodule

// File: rtl/rf_mode_seq.sv
module rf_mode_seq
    import rfseq_pkg::*;
#(
    parameter int CYC_PER_MS = 125000,
    parameter int PWR_MS     = 1,
    parameter int FIRST_MS   = 40,
    parameter int NEXT_MS    = 20,
    parameter int SWITCH_MS  = 5,
    parameter int PRE_MS     = 20,
    parameter int LOCK_N     = 3,
    parameter int BIT_CYC    = 26042,
    parameter int CH_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ch_req,
    input  logic [CH_W-1:0] ch_num,
    input  logic            tx_req,
    input  logic            lock_det,
    input  logic            ld_done,
    input  logic            tx_din,
    output logic            ld_start,
    output logic [CH_W-1:0] ld_chan,
    output logic            pwr_en,
    output logic            txsel_n,
    output logic            rxsel_n,
    output logic            ready,
    output logic            unlock_err,
    output logic            tx_dout
);
    localparam int MAX_MS = max_int(max_int(max_int(PWR_MS, FIRST_MS),
                                            max_int(NEXT_MS, SWITCH_MS)), PRE_MS);
    localparam int MS_W   = $clog2(MAX_MS + 1);
    localparam int LW     = $clog2(LOCK_N + 1);

    seq_state_t      state, state_nx;
    logic [MS_W-1:0] win_target;
    logic            win_done;
    logic            win_restart;
    logic            pend_q;
    logic [CH_W-1:0] pend_ch_q;
    logic [CH_W-1:0] cur_ch_q;
    logic            first_done_q;
    logic            err_q;
    logic [LW-1:0]   lk_cnt_q;
    logic            pre_bit;
    logic            enter_load;

    assign win_restart = (state_nx != state);
    assign enter_load  = (state_nx == ST_LOAD_GO) && (state != ST_LOAD_GO);

    // window length chosen by the state being timed
    always_comb begin
        unique case (state)
            ST_PWR_OFF, ST_PWR_ON:     win_target = MS_W'(PWR_MS);
            ST_CH_SETTLE:              win_target = first_done_q ? MS_W'(NEXT_MS) : MS_W'(FIRST_MS);
            ST_RX_SETTLE, ST_TX_SETTLE: win_target = MS_W'(SWITCH_MS);
            ST_TX_PRE:                 win_target = MS_W'(PRE_MS);
            default:                   win_target = '0;
        endcase
    end

    rfseq_ms_window #(
        .CYC_PER_MS (CYC_PER_MS),
        .MS_W       (MS_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (win_restart),
        .target_ms (win_target),
        .expired   (win_done)
    );

    rfseq_preamble #(
        .BIT_CYC (BIT_CYC)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_TX_PRE),
        .bit_o (pre_bit)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWR_OFF:   if (win_done) state_nx = ST_PWR_ON;
            ST_PWR_ON:    if (win_done) state_nx = ST_IDLE_RX;
            ST_IDLE_RX:   if (pend_q) state_nx = ST_LOAD_GO;
            ST_LOAD_GO:   state_nx = ST_LOAD_WAIT;
            ST_LOAD_WAIT: if (ld_done) state_nx = ST_CH_SETTLE;
            ST_CH_SETTLE: if (win_done) state_nx = ST_LOCK_CHK;
            ST_LOCK_CHK: begin
                if (!lock_det)                          state_nx = ST_IDLE_RX;
                else if (lk_cnt_q == LW'(LOCK_N - 1))   state_nx = ST_RX_READY;
            end
            ST_RX_SETTLE: begin
                if (pend_q)        state_nx = ST_LOAD_GO;
                else if (win_done) state_nx = ST_RX_READY;
            end
            ST_RX_READY: begin
                if (pend_q)      state_nx = ST_LOAD_GO;
                else if (tx_req) state_nx = ST_TX_SETTLE;
            end
            ST_TX_SETTLE: begin
                if (pend_q)        state_nx = ST_LOAD_GO;
                else if (!tx_req)  state_nx = ST_RX_SETTLE;
                else if (win_done) state_nx = ST_TX_PRE;
            end
            ST_TX_PRE: begin
                if (pend_q)        state_nx = ST_LOAD_GO;
                else if (!tx_req)  state_nx = ST_RX_SETTLE;
                else if (win_done) state_nx = ST_TX_READY;
            end
            ST_TX_READY: begin
                if (pend_q)       state_nx = ST_LOAD_GO;
                else if (!tx_req) state_nx = ST_RX_SETTLE;
            end
            default: state_nx = ST_PWR_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWR_OFF;
        else        state <= state_nx;
    end

    // request capture, channel, history and lock bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_ch_q    <= '0;
            cur_ch_q     <= '0;
            first_done_q <= 1'b0;
            err_q        <= 1'b0;
            lk_cnt_q     <= '0;
        end else begin
            if (ch_req) begin
                pend_q    <= 1'b1;
                pend_ch_q <= ch_num;
            end else if (enter_load) begin
                pend_q <= 1'b0;
            end
            if (enter_load) begin
                cur_ch_q <= pend_ch_q;
                err_q    <= 1'b0;
            end else if (state == ST_LOCK_CHK && !lock_det) begin
                err_q <= 1'b1;
            end
            if (state == ST_CH_SETTLE && state_nx == ST_LOCK_CHK)
                first_done_q <= 1'b1;
            if (state == ST_LOCK_CHK) lk_cnt_q <= lk_cnt_q + 1'b1;
            else                      lk_cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        pwr_en   = (state != ST_PWR_OFF);
        ld_start = (state == ST_LOAD_GO);
        ready    = (state == ST_RX_READY) || (state == ST_TX_READY);
        unique case (state)
            ST_IDLE_RX, ST_LOAD_GO, ST_LOAD_WAIT, ST_CH_SETTLE,
            ST_LOCK_CHK, ST_RX_SETTLE, ST_RX_READY: begin
                rxsel_n = 1'b0;
                txsel_n = 1'b1;
            end
            ST_TX_SETTLE, ST_TX_PRE, ST_TX_READY: begin
                rxsel_n = 1'b1;
                txsel_n = 1'b0;
            end
            default: begin
                rxsel_n = 1'b1;
                txsel_n = 1'b1;
            end
        endcase
        unique case (state)
            ST_TX_PRE:   tx_dout = pre_bit;
            ST_TX_READY: tx_dout = tx_din;
            default:     tx_dout = 1'b0;
        endcase
    end

    assign ld_chan    = cur_ch_q;
    assign unlock_err = err_q;

    // R2: the two selects are mutually exclusive
    p_sel_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!txsel_n && !rxsel_n));

    // R2: no select is driven active without supply
    p_sel_needs_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (txsel_n && rxsel_n));

    // R1: supply turns on with both selects parked high
    p_pwr_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> (txsel_n && rxsel_n));

    // R3: loader is started only with the receiver selected
    p_load_in_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_start |-> (!rxsel_n && txsel_n));

    // R10: ready means exactly one path is selected
    p_ready_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (txsel_n != rxsel_n));

    // R6: a failed lock check never coexists with ready
    p_err_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_err |-> !ready);

    // R12: the loader channel only moves together with a start pulse
    p_chan_move_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ld_chan) |-> ld_start);

endmodule

// File: tb/rf_mode_seq_test.sv
module rf_mode_seq_test;

    localparam int C     = 4;
    localparam int PWR   = 1;
    localparam int FIRST = 40;
    localparam int NEXT  = 20;
    localparam int SW    = 5;
    localparam int PRE   = 20;
    localparam int LK    = 3;
    localparam int BITC  = 2;
    localparam int CHW   = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ch_req = 1'b0;
    logic [CHW-1:0] ch_num = '0;
    logic           tx_req = 1'b0;
    logic           lock_det = 1'b1;
    logic           ld_done = 1'b0;
    logic           tx_din = 1'b0;
    logic           ld_start;
    logic [CHW-1:0] ld_chan;
    logic           pwr_en, txsel_n, rxsel_n, ready, unlock_err, tx_dout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rf_mode_seq #(
        .CYC_PER_MS (C), .PWR_MS (PWR), .FIRST_MS (FIRST), .NEXT_MS (NEXT),
        .SWITCH_MS (SW), .PRE_MS (PRE), .LOCK_N (LK), .BIT_CYC (BITC), .CH_W (CHW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ch_req (ch_req), .ch_num (ch_num),
        .tx_req (tx_req), .lock_det (lock_det), .ld_done (ld_done), .tx_din (tx_din),
        .ld_start (ld_start), .ld_chan (ld_chan), .pwr_en (pwr_en),
        .txsel_n (txsel_n), .rxsel_n (rxsel_n), .ready (ready),
        .unlock_err (unlock_err), .tx_dout (tx_dout)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // request a channel, check the loader start, return after ld_done is driven
    task automatic issue_load(input int ch, input string req);
        int w;
        ch_num = CHW'(ch);
        ch_req = 1'b1;
        tick();
        ch_req = 1'b0;
        w = 0;
        while (!ld_start && w < 20) begin
            tick();
            w++;
        end
        check({req, " ld_start seen"}, int'(ld_start), 1);
        check("R12 ld_chan at start", int'(ld_chan), ch);
        check("R3 rx selected at load", int'(rxsel_n), 0);
        check("R3 tx deselected at load", int'(txsel_n), 1);
        check("R6 error cleared at load", int'(unlock_err), 0);
        tick();
        tick();
        ld_done = 1'b1;
    endtask

    // count edges after ld_done until ready, optional lock glitch window
    task automatic wait_ready_after_load(input int exp, input string req,
                                         input int g_from, input int g_to);
        int n = 0;
        bit seen = 1'b0;
        while (!seen && n < exp + 10) begin
            tick();
            n++;
            ld_done = 1'b0;
            if (n == g_from) lock_det = 1'b0;
            if (n == g_to)   lock_det = 1'b1;
            if (n == exp - 1) check({req, " ready not yet"}, int'(ready), 0);
            if (ready) seen = 1'b1;
        end
        check({req, " ready latency"}, n, exp);
    endtask

    task automatic t_reset_power();
        rst_n = 1'b0;
        repeat (3) tick();
        check("R1 reset pwr_en", int'(pwr_en), 0);
        check("R1 reset txsel_n", int'(txsel_n), 1);
        check("R1 reset rxsel_n", int'(rxsel_n), 1);
        check("R10 reset ready", int'(ready), 0);
        rst_n = 1'b1;
        for (int n = 1; n <= 2 * (C * PWR + 1); n++) begin
            tick();
            if (n == C * PWR)           check("R1 pwr still off", int'(pwr_en), 0);
            if (n == C * PWR + 1) begin
                check("R1 pwr on", int'(pwr_en), 1);
                check("R1 tx parked", int'(txsel_n), 1);
                check("R1 rx parked", int'(rxsel_n), 1);
            end
            if (n == 2 * (C * PWR + 1) - 1) check("R1 rx not yet", int'(rxsel_n), 1);
        end
        check("R1 rx selected", int'(rxsel_n), 0);
    endtask

    task automatic t_tx_without_channel(input string req);
        tx_req = 1'b1;
        for (int n = 0; n < 30; n++) begin
            tick();
            if (txsel_n !== 1'b1 || ready !== 1'b0) begin
                check({req, " tx ignored"}, int'(txsel_n), 1);
                n = 30;
            end
        end
        check({req, " txsel_n held"}, int'(txsel_n), 1);
        check({req, " ready held low"}, int'(ready), 0);
        tx_req = 1'b0;
        tick();
    endtask

    task automatic t_first_load();
        issue_load(17, "R4");
        wait_ready_after_load(C * FIRST + LK + 2, "R4", 0, 0);
        check("R10 rx ready selects", int'(rxsel_n), 0);
    endtask

    task automatic t_second_load_glitch();
        issue_load(42, "R5");
        // R6 low pulse well inside the window must be ignored
        wait_ready_after_load(C * NEXT + LK + 2, "R5 R6", 10, 16);
        check("R6 no error after glitch", int'(unlock_err), 0);
    endtask

    // raise tx_req from receive-ready, check preamble and ready timing
    task automatic t_go_tx();
        int pre_start = C * SW + 2;
        int exp_rdy   = C * (SW + PRE) + 3;
        int n = 0;
        bit seen = 1'b0;
        tx_din = 1'b1;
        tx_req = 1'b1;
        while (!seen && n < exp_rdy + 10) begin
            tick();
            n++;
            if (n == 1) begin
                check("R8 tx selected", int'(txsel_n), 0);
                check("R8 rx released", int'(rxsel_n), 1);
            end
            if (n < pre_start && n == 3) check("R9 quiet in settle", int'(tx_dout), 0);
            if (n >= pre_start && n < pre_start + 8)
                check("R9 preamble bit", int'(tx_dout),
                      (((n - pre_start) / BITC) % 2 == 0) ? 1 : 0);
            if (n == exp_rdy - 1) check("R8 ready not yet", int'(ready), 0);
            if (ready) seen = 1'b1;
        end
        check("R8 tx ready latency", n, exp_rdy);
        check("R9 host data passes", int'(tx_dout), 1);
        tx_din = 1'b0;
        tick();
        check("R9 host data follows", int'(tx_dout), 0);
    endtask

    task automatic t_ch_req_in_tx();
        ch_num = CHW'(99);
        ch_req = 1'b1;
        tick();
        ch_req = 1'b0;
        check("R3 still tx one edge later", int'(txsel_n), 0);
        tick();
        check("R3 back to rx", int'(rxsel_n), 0);
        check("R3 tx released", int'(txsel_n), 1);
        check("R3 load started", int'(ld_start), 1);
        check("R12 ld_chan from tx", int'(ld_chan), 99);
        tx_req = 1'b0;
        tick();
        tick();
        ld_done = 1'b1;
        wait_ready_after_load(C * NEXT + LK + 2, "R5 after tx", 0, 0);
    endtask

    task automatic t_back_to_rx();
        int exp = C * SW + 1 + 1;
        int n = 0;
        bit seen = 1'b0;
        tx_req = 1'b0;
        while (!seen && n < exp + 10) begin
            tick();
            n++;
            if (n == 1) check("R7 rx selected", int'(rxsel_n), 0);
            if (n == exp - 1) check("R7 ready not yet", int'(ready), 0);
            if (ready) seen = 1'b1;
        end
        check("R7 rx ready latency", n, exp);
        check("R7 tx released", int'(txsel_n), 1);
    endtask

    task automatic t_lock_fail();
        int exp = C * NEXT + 3;
        issue_load(5, "R6");
        lock_det = 1'b0;
        for (int n = 1; n <= exp; n++) begin
            tick();
            ld_done = 1'b0;
            if (n == exp - 1) check("R6 no error yet", int'(unlock_err), 0);
        end
        check("R6 error raised", int'(unlock_err), 1);
        check("R6 ready low", int'(ready), 0);
        check("R6 rx kept", int'(rxsel_n), 0);
        lock_det = 1'b1;
        t_tx_without_channel("R11 after fail");
        issue_load(6, "R6 recover");
        wait_ready_after_load(C * NEXT + LK + 2, "R6 recover", 0, 0);
    endtask

    initial begin
        t_reset_power();
        t_tx_without_channel("R11");
        t_first_load();
        t_second_load_glitch();
        t_go_tx();
        t_ch_req_in_tx();
        t_go_tx();
        t_back_to_rx();
        t_lock_fail();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule